// File: doc/BRIEF.md
# Interrupt Distributor Register Bank

This block is the central distributor of a small multi-core interrupt controller. It holds the routing and state for every interrupt source: enable, pending, active, trigger type, priority and CPU target. Software reaches it through a simple word-addressed register port. Each access carries the number of the CPU that issues it. Shared peripheral lines arrive on `src_in`, where line k is source ID 32+k. For each CPU the block presents the best candidate source on a registered request output, and that output feeds that CPU's interface logic.

Each enable, pending or active bit of a source sits at word ID/32, bit ID%32, inside its register window. The enable, pending and active windows each have a set alias and a clear alias. IDs 0–31 are private to each CPU. Their enable, pending and active bits are kept once per CPU. IDs 0–15 are the software-generated range, and their trigger type is fixed to edge.

Top module: `irq_distributor`

## Requirements
- R1: After reset the control bit, every enable, pending and active bit, and every request output are 0.
- R2: Word 0x001 is read-only and returns NUM_SRC/32-1 in bits 4:0, with every other bit 0.
- R3: Enable has a set window at word 0x040+ID/32 and a clear window at word 0x060+ID/32. Writing 1 to bit ID%32 sets or clears that enable. Writing 0 to a bit changes nothing. Both windows read back the current enable bits.
- R4: Pending has a set window at 0x080+ID/32 and a clear window at 0x0A0+ID/32, and both behave like the enable windows. A read returns the effective pending state.
- R5: Active has a set window at 0x0C0+ID/32 and a clear window at 0x0E0+ID/32, and both behave like the enable windows. An active source is never selected.
- R6: Trigger configuration sits at word 0x300+ID/16, in field bits 2*(ID%16)+1 and 2*(ID%16). The upper bit is 1 for edge and 0 for level, and the lower bit reads 0. The fields of IDs 0–15 always read 2'b10, and writes to them are ignored.
- R7: For an edge source, a rising edge on its input sets pending. Pending stays set until it is cleared. A rise in the same cycle as a pending-clear write leaves pending set.
- R8: A level source reads as pending while its input is high and it is not active. This state is not latched.
- R9: Priority is one byte per source at word 0x100+ID/4, byte ID%4. The CPU target is one byte per source at word 0x200+ID/4, byte ID%4, and bit c of that byte routes the source to CPU c. For IDs 0–31 the target byte reads as only the accessing CPU's bit, and writes to it are ignored.
- R10: For each CPU, the candidates are the sources that are enabled, pending, not active and targeted at that CPU. The candidate with the lowest priority value is presented, and a tie goes to the lowest ID. The output follows a state change one clock later.
- R11: The enable, pending and active bits of IDs 0–31 are kept separately for each CPU. An access at a given address reaches the copy of the CPU named on `bus_cpu`.
- R12: Control word 0x000, bit 0, gates forwarding. While it is 0, no request is raised on any CPU.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_cpu | input | CPU_W | Number of the CPU issuing the access |
| bus_addr | input | ADDR_W | Word address |
| bus_we | input | 1 | Write strobe, applied at the clock edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the current address, combinational |
| src_in | input | NUM_SRC-32 | Shared interrupt lines, line k is ID 32+k |
| irq_req | output | NUM_CPUS | Per-CPU request valid |
| irq_id | output | NUM_CPUS*ID_W | Per-CPU selected source ID |
| irq_prio | output | NUM_CPUS*8 | Per-CPU priority of the selected source |

## Verification
The assertions check four properties on every cycle. The control gate suppresses requests one cycle later. The type word and the fixed software-generated configuration always read back their set values. A write of all zeros to an enable window leaves every enable bit unchanged. Priority ordering and tie-breaking by ID are shown only by the bench's scenarios. The same holds for exclusion of active sources, edge latching against a simultaneous clear, level tracking, and the per-CPU copies of the private range.

// File: rtl/irqd_pkg.sv
package irqd_pkg;
    localparam int PRIO_W   = 8;
    localparam int PRIV_IDS = 32;
    localparam int SGI_IDS  = 16;

    // word offsets of the register windows
    localparam int OFS_CTRL   = 'h000;
    localparam int OFS_TYPE   = 'h001;
    localparam int OFS_EN_SET = 'h040;
    localparam int OFS_EN_CLR = 'h060;
    localparam int OFS_PD_SET = 'h080;
    localparam int OFS_PD_CLR = 'h0A0;
    localparam int OFS_AC_SET = 'h0C0;
    localparam int OFS_AC_CLR = 'h0E0;
    localparam int OFS_PRIO   = 'h100;
    localparam int OFS_TGT    = 'h200;
    localparam int OFS_CFG    = 'h300;

    function automatic logic in_win(int addr, int base, int words);
        return (addr >= base) && (addr < base + words);
    endfunction
endpackage

// File: rtl/irqd_edge.sv
module irqd_edge #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] din,
    output logic [W-1:0] rise
);
    logic [W-1:0] prev;

    always_ff @(posedge clk) begin
        if (rst) prev <= '0;
        else     prev <= din;
    end

    assign rise = din & ~prev;
endmodule

// File: rtl/irqd_arbiter.sv
module irqd_arbiter
    import irqd_pkg::*;
#(
    parameter int NUM_SRC = 64,
    parameter int ID_W    = 6
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic [NUM_SRC-1:0]              elig,
    input  logic [NUM_SRC-1:0][PRIO_W-1:0]  prio,
    output logic                            req,
    output logic [ID_W-1:0]                 req_id,
    output logic [PRIO_W-1:0]               req_prio
);
    typedef struct packed {
        logic              found;
        logic [ID_W-1:0]   id;
        logic [PRIO_W-1:0] prio;
    } pick_t;

    pick_t best;

    // strict less-than keeps the lowest ID on equal priority
    always_comb begin
        best = '{found: 1'b0, id: '0, prio: '1};
        for (int i = 0; i < NUM_SRC; i++) begin
            if (elig[i] && (!best.found || prio[i] < best.prio)) begin
                best.found = 1'b1;
                best.id    = ID_W'(i);
                best.prio  = prio[i];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            req      <= 1'b0;
            req_id   <= '0;
            req_prio <= '0;
        end else begin
            req      <= best.found;
            req_id   <= best.found ? best.id : '0;
            req_prio <= best.found ? best.prio : '0;
        end
    end
endmodule

// File: rtl/irq_distributor.sv
module irq_distributor
    import irqd_pkg::*;
#(
    parameter int NUM_CPUS = 2,
    parameter int NUM_SRC  = 64,
    parameter int ADDR_W   = 10,
    localparam int CPU_W   = (NUM_CPUS > 1) ? $clog2(NUM_CPUS) : 1,
    localparam int ID_W    = $clog2(NUM_SRC),
    localparam int NUM_SHR = NUM_SRC - PRIV_IDS
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic [CPU_W-1:0]           bus_cpu,
    input  logic [ADDR_W-1:0]          bus_addr,
    input  logic                       bus_we,
    input  logic [31:0]                bus_wdata,
    output logic [31:0]                bus_rdata,
    input  logic [NUM_SHR-1:0]         src_in,
    output logic [NUM_CPUS-1:0]        irq_req,
    output logic [NUM_CPUS*ID_W-1:0]   irq_id,
    output logic [NUM_CPUS*PRIO_W-1:0] irq_prio
);
    localparam int NW_BIT  = NUM_SRC / 32;
    localparam int NW_BYTE = NUM_SRC / 4;
    localparam int NW_CFG  = NUM_SRC / 16;

    // state
    logic                               ctrl_en;
    logic [NUM_CPUS-1:0][31:0]          en_bk, pd_bk, ac_bk;
    logic [NUM_SHR-1:0]                 en_sh, pd_sh, ac_sh;
    logic [NUM_SRC-1:0][PRIO_W-1:0]     prio;
    logic [NUM_SHR-1:0][NUM_CPUS-1:0]   tgt;
    logic [NUM_SRC-1:0]                 cfg_edge;

    logic [NUM_SHR-1:0] rise;
    logic [NUM_SHR-1:0] pd_eff_sh;
    int                 aw;

    assign aw = int'(bus_addr);

    irqd_edge #(.W(NUM_SHR)) u_edge (
        .clk  (clk),
        .rst  (rst),
        .din  (src_in),
        .rise (rise)
    );

    // level sources follow the line unless active
    always_comb begin
        for (int j = 0; j < NUM_SHR; j++)
            pd_eff_sh[j] = pd_sh[j] |
                (~cfg_edge[j+PRIV_IDS] & src_in[j] & ~ac_sh[j]);
    end

    // register writes
    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_en  <= 1'b0;
            en_bk    <= '0;
            pd_bk    <= '0;
            ac_bk    <= '0;
            en_sh    <= '0;
            pd_sh    <= '0;
            ac_sh    <= '0;
            prio     <= '0;
            tgt      <= '0;
            cfg_edge <= NUM_SRC'({SGI_IDS{1'b1}});
        end else begin
            if (bus_we && aw == OFS_CTRL) ctrl_en <= bus_wdata[0];

            // private range: banked by accessing CPU, word 0
            for (int i = 0; i < PRIV_IDS; i++) begin
                if (bus_we && bus_wdata[i]) begin
                    if (aw == OFS_EN_SET) en_bk[bus_cpu][i] <= 1'b1;
                    if (aw == OFS_EN_CLR) en_bk[bus_cpu][i] <= 1'b0;
                    if (aw == OFS_PD_SET) pd_bk[bus_cpu][i] <= 1'b1;
                    if (aw == OFS_PD_CLR) pd_bk[bus_cpu][i] <= 1'b0;
                    if (aw == OFS_AC_SET) ac_bk[bus_cpu][i] <= 1'b1;
                    if (aw == OFS_AC_CLR) ac_bk[bus_cpu][i] <= 1'b0;
                end
            end

            // shared range
            for (int j = 0; j < NUM_SHR; j++) begin
                if (bus_we && bus_wdata[(j+PRIV_IDS)%32]) begin
                    if (aw == OFS_EN_SET + (j+PRIV_IDS)/32) en_sh[j] <= 1'b1;
                    if (aw == OFS_EN_CLR + (j+PRIV_IDS)/32) en_sh[j] <= 1'b0;
                    if (aw == OFS_PD_SET + (j+PRIV_IDS)/32) pd_sh[j] <= 1'b1;
                    if (aw == OFS_PD_CLR + (j+PRIV_IDS)/32) pd_sh[j] <= 1'b0;
                    if (aw == OFS_AC_SET + (j+PRIV_IDS)/32) ac_sh[j] <= 1'b1;
                    if (aw == OFS_AC_CLR + (j+PRIV_IDS)/32) ac_sh[j] <= 1'b0;
                end
                // a line edge outranks a same-cycle clear
                if (rise[j] && cfg_edge[j+PRIV_IDS]) pd_sh[j] <= 1'b1;
                if (bus_we && aw == OFS_TGT + (j+PRIV_IDS)/4)
                    tgt[j] <= bus_wdata[8*((j+PRIV_IDS)%4) +: NUM_CPUS];
            end

            for (int i = 0; i < NUM_SRC; i++) begin
                if (bus_we && aw == OFS_PRIO + i/4)
                    prio[i] <= bus_wdata[8*(i%4) +: PRIO_W];
            end

            for (int i = SGI_IDS; i < NUM_SRC; i++) begin
                if (bus_we && aw == OFS_CFG + i/16)
                    cfg_edge[i] <= bus_wdata[2*(i%16)+1];
            end
        end
    end

    // views as seen by the accessing CPU
    logic [NUM_SRC-1:0]             en_v, pd_v, ac_v;
    logic [NUM_SRC-1:0][7:0]        tgt_v;

    always_comb begin
        en_v = {en_sh, en_bk[bus_cpu]};
        pd_v = {pd_eff_sh, pd_bk[bus_cpu]};
        ac_v = {ac_sh, ac_bk[bus_cpu]};
        for (int i = 0; i < PRIV_IDS; i++) tgt_v[i] = 8'(1) << bus_cpu;
        for (int j = 0; j < NUM_SHR; j++) tgt_v[j+PRIV_IDS] = 8'(tgt[j]);
    end

    // read mux
    always_comb begin
        bus_rdata = '0;
        if (aw == OFS_CTRL) begin
            bus_rdata[0] = ctrl_en;
        end else if (aw == OFS_TYPE) begin
            bus_rdata[4:0] = 5'(NW_BIT - 1);
        end else if (in_win(aw, OFS_EN_SET, NW_BIT) || in_win(aw, OFS_EN_CLR, NW_BIT)) begin
            for (int b = 0; b < 32; b++)
                bus_rdata[b] = en_v[((aw - OFS_EN_SET) % 32) * 32 + b];
        end else if (in_win(aw, OFS_PD_SET, NW_BIT) || in_win(aw, OFS_PD_CLR, NW_BIT)) begin
            for (int b = 0; b < 32; b++)
                bus_rdata[b] = pd_v[((aw - OFS_PD_SET) % 32) * 32 + b];
        end else if (in_win(aw, OFS_AC_SET, NW_BIT) || in_win(aw, OFS_AC_CLR, NW_BIT)) begin
            for (int b = 0; b < 32; b++)
                bus_rdata[b] = ac_v[((aw - OFS_AC_SET) % 32) * 32 + b];
        end else if (in_win(aw, OFS_PRIO, NW_BYTE)) begin
            for (int k = 0; k < 4; k++)
                bus_rdata[8*k +: 8] = prio[(aw - OFS_PRIO) * 4 + k];
        end else if (in_win(aw, OFS_TGT, NW_BYTE)) begin
            for (int k = 0; k < 4; k++)
                bus_rdata[8*k +: 8] = tgt_v[(aw - OFS_TGT) * 4 + k];
        end else if (in_win(aw, OFS_CFG, NW_CFG)) begin
            for (int k = 0; k < 16; k++)
                bus_rdata[2*k+1] = cfg_edge[(aw - OFS_CFG) * 16 + k];
        end
    end

    // per-CPU candidate selection
    for (genvar c = 0; c < NUM_CPUS; c++) begin : g_cpu
        logic [NUM_SRC-1:0] elig;

        always_comb begin
            for (int i = 0; i < PRIV_IDS; i++)
                elig[i] = ctrl_en & en_bk[c][i] & pd_bk[c][i] & ~ac_bk[c][i];
            for (int j = 0; j < NUM_SHR; j++)
                elig[j+PRIV_IDS] = ctrl_en & en_sh[j] & pd_eff_sh[j] &
                                   ~ac_sh[j] & tgt[j][c];
        end

        irqd_arbiter #(.NUM_SRC(NUM_SRC), .ID_W(ID_W)) u_arb (
            .clk      (clk),
            .rst      (rst),
            .elig     (elig),
            .prio     (prio),
            .req      (irq_req[c]),
            .req_id   (irq_id[c*ID_W +: ID_W]),
            .req_prio (irq_prio[c*PRIO_W +: PRIO_W])
        );
    end
endmodule

// File: rtl/irqd_checker.sv
module irqd_checker
    import irqd_pkg::*;
#(
    parameter int NUM_CPUS = 2,
    parameter int NUM_SRC  = 64,
    parameter int ADDR_W   = 10
) (
    input logic                              clk,
    input logic                              rst,
    input logic [ADDR_W-1:0]                 bus_addr,
    input logic                              bus_we,
    input logic [31:0]                       bus_wdata,
    input logic [31:0]                       bus_rdata,
    input logic                              ctrl_en,
    input logic [NUM_CPUS-1:0][31:0]         en_bk,
    input logic [NUM_SRC-PRIV_IDS-1:0]       en_sh,
    input logic [NUM_CPUS-1:0]               irq_req
);
    localparam int NW_BIT = NUM_SRC / 32;

    logic en_zero_wr;
    assign en_zero_wr = bus_we && (bus_wdata == '0) &&
        (in_win(int'(bus_addr), OFS_EN_SET, NW_BIT) ||
         in_win(int'(bus_addr), OFS_EN_CLR, NW_BIT));

    a_r12_gate_blocks_req: assert property (@(posedge clk) disable iff (rst)
        !ctrl_en |=> (irq_req == '0));

    a_r12_req_needs_gate: assert property (@(posedge clk) disable iff (rst)
        (irq_req != '0) |-> $past(ctrl_en));

    a_r2_type_word: assert property (@(posedge clk) disable iff (rst)
        (int'(bus_addr) == OFS_TYPE) |-> (bus_rdata == 32'(NW_BIT - 1)));

    a_r6_sgi_cfg_fixed: assert property (@(posedge clk) disable iff (rst)
        (int'(bus_addr) == OFS_CFG) |-> (bus_rdata == 32'hAAAA_AAAA));

    a_r3_zero_write_no_effect: assert property (@(posedge clk) disable iff (rst)
        en_zero_wr |=> ($stable(en_sh) && $stable(en_bk)));
endmodule

bind irq_distributor irqd_checker #(
    .NUM_CPUS (NUM_CPUS),
    .NUM_SRC  (NUM_SRC),
    .ADDR_W   (ADDR_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .ctrl_en   (ctrl_en),
    .en_bk     (en_bk),
    .en_sh     (en_sh),
    .irq_req   (irq_req)
);

// File: tb/irq_distributor_bench.sv
module irq_distributor_bench;
    import irqd_pkg::*;

    localparam int NUM_CPUS = 2;
    localparam int NUM_SRC  = 64;
    localparam int ADDR_W   = 10;
    localparam int ID_W     = 6;

    logic                       clk = 1'b0;
    logic                       rst = 1'b1;
    logic [0:0]                 bus_cpu = '0;
    logic [ADDR_W-1:0]          bus_addr = '0;
    logic                       bus_we = 1'b0;
    logic [31:0]                bus_wdata = '0;
    logic [31:0]                bus_rdata;
    logic [NUM_SRC-33:0]        src_in = '0;
    logic [NUM_CPUS-1:0]        irq_req;
    logic [NUM_CPUS*ID_W-1:0]   irq_id;
    logic [NUM_CPUS*8-1:0]      irq_prio;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    irq_distributor #(.NUM_CPUS(NUM_CPUS), .NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W)) u_irq_distributor (
        .clk, .rst, .bus_cpu, .bus_addr, .bus_we, .bus_wdata, .bus_rdata,
        .src_in, .irq_req, .irq_id, .irq_prio
    );

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    task automatic wr(int cpu, int addr, logic [31:0] d);
        @(negedge clk);
        bus_cpu = 1'(cpu); bus_addr = ADDR_W'(addr); bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd_chk(string tag, int cpu, int addr, logic [31:0] exp);
        bus_cpu = 1'(cpu); bus_addr = ADDR_W'(addr);
        #1;
        chk(tag, bus_rdata, exp);
    endtask

    task automatic settle();
        @(negedge clk);
    endtask

    task automatic req_chk(string tag, int cpu, logic v, int id, int p);
        chk({tag, " valid"}, 32'(irq_req[cpu]), 32'(v));
        if (v) begin
            chk({tag, " id"},   32'(irq_id[cpu*ID_W +: ID_W]), 32'(id));
            chk({tag, " prio"}, 32'(irq_prio[cpu*8 +: 8]),     32'(p));
        end
    endtask

    task automatic t_reset();
        rd_chk("R1 ctrl", 0, OFS_CTRL, 0);
        rd_chk("R1 enable", 0, OFS_EN_SET + 1, 0);
        rd_chk("R1 pending", 1, OFS_PD_SET, 0);
        chk("R1 no request", 32'(irq_req), 0);
        rd_chk("R2 type", 0, OFS_TYPE, 1);
    endtask

    task automatic t_enable_alias();
        wr(0, OFS_EN_SET + 1, 32'h6);
        rd_chk("R3 set read", 0, OFS_EN_SET + 1, 32'h6);
        rd_chk("R3 clr read", 0, OFS_EN_CLR + 1, 32'h6);
        wr(0, OFS_EN_CLR + 1, 32'h2);
        rd_chk("R3 clear one", 0, OFS_EN_SET + 1, 32'h4);
        wr(0, OFS_EN_SET + 1, 32'h0);
        rd_chk("R3 zero write", 0, OFS_EN_SET + 1, 32'h4);
        wr(0, OFS_EN_CLR + 1, 32'h4);
        rd_chk("R3 all clear", 0, OFS_EN_CLR + 1, 32'h0);
    endtask

    task automatic t_config();
        rd_chk("R6 sgi cfg", 0, OFS_CFG, 32'hAAAA_AAAA);
        wr(0, OFS_CFG, 32'h0);
        rd_chk("R6 sgi write ignored", 0, OFS_CFG, 32'hAAAA_AAAA);
        wr(0, OFS_CFG + 2, 32'h8);
        rd_chk("R6 id33 edge", 0, OFS_CFG + 2, 32'h8);
    endtask

    task automatic t_edge();
        @(negedge clk); src_in[1] = 1'b1;
        @(negedge clk); src_in[1] = 1'b0;
        settle();
        rd_chk("R7 edge latched", 0, OFS_PD_SET + 1, 32'h2);
        wr(0, OFS_PD_CLR + 1, 32'h2);
        rd_chk("R4 pending cleared", 0, OFS_PD_CLR + 1, 32'h0);
        wr(0, OFS_PD_SET + 1, 32'h2);
        rd_chk("R4 pending set", 0, OFS_PD_SET + 1, 32'h2);
        // clear and rise in the same cycle
        @(negedge clk);
        bus_cpu = 1'b0; bus_addr = ADDR_W'(OFS_PD_CLR + 1); bus_wdata = 32'h2;
        bus_we = 1'b1; src_in[1] = 1'b1;
        @(negedge clk);
        bus_we = 1'b0; src_in[1] = 1'b0;
        rd_chk("R7 rise beats clear", 0, OFS_PD_SET + 1, 32'h2);
        wr(0, OFS_PD_CLR + 1, 32'h2);
        rd_chk("R7 cleared after", 0, OFS_PD_SET + 1, 32'h0);
    endtask

    task automatic t_level();
        @(negedge clk); src_in[2] = 1'b1;
        rd_chk("R8 level high", 0, OFS_PD_SET + 1, 32'h4);
        wr(0, OFS_AC_SET + 1, 32'h4);
        rd_chk("R5 active read", 0, OFS_AC_CLR + 1, 32'h4);
        rd_chk("R8 hidden while active", 0, OFS_PD_SET + 1, 32'h0);
        wr(0, OFS_AC_CLR + 1, 32'h4);
        rd_chk("R8 back after active clear", 0, OFS_PD_SET + 1, 32'h4);
        @(negedge clk); src_in[2] = 1'b0;
        rd_chk("R8 not latched", 0, OFS_PD_SET + 1, 32'h0);
    endtask

    task automatic t_select();
        wr(0, OFS_CTRL, 32'h1);
        wr(0, OFS_TGT + 10, 32'h0000_0101);
        rd_chk("R9 target", 0, OFS_TGT + 10, 32'h0000_0101);
        wr(0, OFS_PRIO + 10, 32'h0000_80A0);
        rd_chk("R9 priority", 1, OFS_PRIO + 10, 32'h0000_80A0);
        wr(0, OFS_EN_SET + 1, 32'h300);
        wr(0, OFS_PD_SET + 1, 32'h300);
        settle();
        req_chk("R10 lower value wins", 0, 1'b1, 41, 'h80);
        req_chk("R10 untargeted cpu", 1, 1'b0, 0, 0);
        wr(0, OFS_PRIO + 10, 32'h0000_A0A0);
        settle();
        req_chk("R10 tie lowest id", 0, 1'b1, 40, 'hA0);
        wr(0, OFS_AC_SET + 1, 32'h100);
        settle();
        req_chk("R5 active skipped", 0, 1'b1, 41, 'hA0);
        wr(0, OFS_CTRL, 32'h0);
        settle();
        req_chk("R12 gate off", 0, 1'b0, 0, 0);
        rd_chk("R12 ctrl read", 0, OFS_CTRL, 0);
        wr(0, OFS_CTRL, 32'h1);
        settle();
        req_chk("R12 gate on", 0, 1'b1, 41, 'hA0);
    endtask

    task automatic t_banking();
        wr(1, OFS_EN_SET, 32'h20);
        wr(1, OFS_PD_SET, 32'h20);
        wr(1, OFS_PRIO + 1, 32'h0000_1000);
        rd_chk("R11 cpu0 enable copy", 0, OFS_EN_SET, 32'h0);
        rd_chk("R11 cpu1 enable copy", 1, OFS_EN_SET, 32'h20);
        rd_chk("R11 cpu0 pending copy", 0, OFS_PD_SET, 32'h0);
        rd_chk("R9 private target cpu1", 1, OFS_TGT + 1, 32'h0202_0202);
        wr(0, OFS_TGT + 1, 32'h0);
        rd_chk("R9 private target cpu0", 0, OFS_TGT + 1, 32'h0101_0101);
        settle();
        req_chk("R11 cpu1 private", 1, 1'b1, 5, 'h10);
        req_chk("R11 cpu0 unaffected", 0, 1'b1, 41, 'hA0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        settle();
        t_reset();
        t_enable_alias();
        t_config();
        t_edge();
        t_level();
        t_select();
        t_banking();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule